// File: doc/BRIEF.md
# Pin Direction Override Arbiter

This block decides whether each of eight general-purpose pins drives or receives. Software programs a byte-wide direction register over a small register bus. Several on-chip peripherals can take over a pin's direction while they are active: a pulse-width unit, a timer's output-compare channels, and a serial interface. Each pin has a fixed list of peripherals that may claim it. The block resolves these claims by priority and produces an output-enable vector for the pad ring.

A peripheral claim changes only the effective direction. The stored register keeps the value software last wrote, and that value reads back unchanged. When every claim is released, the pin returns to the software setting with no further register access. The top pin also has a shutdown input that forces it to receive.

Each pin is resolved by its own arbiter. The arbiter first names a winning source for the pin: soft, shutdown, PWM, timer or serial. A `unique case` on that source then sets the pin's output enable. The block has no sequential state apart from the direction register. The winning source and the output-enable vector are both combinational.

Top module: `pdo_arbiter`

## Requirements
- R1: While reset is held low, and after it is released with no overrides asserted, the direction register reads 0x00 and `pin_oe` is 0x00, so every pin is an input.
- R2: A write with `bus_wr`=1 and `bus_addr` equal to `DIR_ADDR` (default 4'hA) loads `bus_wdata` into the register on the next rising clock edge. The new value is not visible before that edge.
- R3: A write to any other address leaves the register unchanged. A read of any other address returns 0x00 on `bus_rdata`.
- R4: With no override input asserted, `pin_oe[i]` equals register bit i. A bit value of 1 means output and 0 means input.
- R5: `pwm_chan_en[i]`=1 forces `pin_oe[i]`=1 on every bit i, and outranks the timer and serial claims on that bit.
- R6: `pwm_shut_en`=1 forces `pin_oe[7]`=0. This holds against a set register bit and against `pwm_chan_en[7]`.
- R7: On bits 2 to 0, `tim_oc_en[i]`=1 forces `pin_oe[i]`=1 when the PWM does not claim the pin, and outranks the serial claim.
- R8: Serial claims reach only bit 0 (`ser_en[0]`, `ser_out[0]`) and bit 2 (`ser_en[1]`, `ser_out[1]`). When neither the PWM nor the timer claims the pin, the pin takes the `ser_out` value: 1 for output, 0 for input.
- R9: `pwm_shut_en` has no effect on bits 6 to 0.
- R10: Override inputs never change the stored register. The readback equals the last written value while overrides are asserted.
- R11: `pin_oe` follows a change on an override input within the same clock cycle, with no register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Register bus address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Readback, the register value when the address matches, else 0 |
| pwm_chan_en | input | WIDTH | Per-channel PWM enables |
| pwm_shut_en | input | 1 | PWM shutdown enable for the top pin |
| tim_oc_en | input | 3 | Timer output-compare enables for bits 2 to 0 |
| ser_en | input | 2 | Serial claim enables for bit 0 (index 0) and bit 2 (index 1) |
| ser_out | input | 2 | Serial requested direction for the same two bits, 1 for output |
| pin_oe | output | WIDTH | Effective output enable per pin |

## Verification
A register write becomes visible on `bus_rdata` and on `pin_oe` one rising edge after the strobe is sampled. Every override result is due in the same cycle, because the override path is purely combinational. The bench drives all inputs just after a falling edge. It checks register effects only after the following rising edge, and first confirms the old value just before that edge. It checks override effects a fraction of a nanosecond after the inputs change, before any clock edge can intervene. This shows that no register lies in the override path.

// File: rtl/pdo_pkg.sv
package pdo_pkg;
    localparam int TIM_BITS   = 3;
    localparam int SER_BIT_LO = 0;
    localparam int SER_BIT_HI = 2;

    typedef enum logic [2:0] {
        SRC_SOFT = 3'd0,
        SRC_SHUT = 3'd1,
        SRC_PWM  = 3'd2,
        SRC_TIM  = 3'd3,
        SRC_SER  = 3'd4
    } src_e;
endpackage

// File: rtl/pdo_dir_reg.sv
module pdo_dir_reg #(
    parameter int WIDTH  = 8,
    parameter int ADDR_W = 4,
    parameter logic [ADDR_W-1:0] ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [WIDTH-1:0]  wdata,
    output logic [WIDTH-1:0]  dir_q,
    output logic [WIDTH-1:0]  rdata
);
    logic hit;

    assign hit = (addr == ADDR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= '0;
        end else if (wr && hit) begin
            dir_q <= wdata;
        end
    end

    always_comb begin
        rdata = hit ? dir_q : '0;
    end
endmodule

// File: rtl/pdo_bit_arb.sv
module pdo_bit_arb #(
    parameter bit HAS_SHUT = 1'b0,
    parameter bit HAS_TIM  = 1'b0,
    parameter bit HAS_SER  = 1'b0
) (
    input  logic soft_dir,
    input  logic pwm_en,
    input  logic shut_en,
    input  logic tim_en,
    input  logic ser_en,
    input  logic ser_out,
    output logic oe
);
    import pdo_pkg::*;

    src_e src;

    always_comb begin
        if (HAS_SHUT && shut_en)     src = SRC_SHUT;
        else if (pwm_en)             src = SRC_PWM;
        else if (HAS_TIM && tim_en)  src = SRC_TIM;
        else if (HAS_SER && ser_en)  src = SRC_SER;
        else                         src = SRC_SOFT;
    end

    always_comb begin
        oe = soft_dir;
        unique case (src)
            SRC_SOFT: oe = soft_dir;
            SRC_SHUT: oe = 1'b0;
            SRC_PWM:  oe = 1'b1;
            SRC_TIM:  oe = 1'b1;
            SRC_SER:  oe = ser_out;
            default:  oe = soft_dir;
        endcase
    end
endmodule

// File: rtl/pdo_arbiter.sv
module pdo_arbiter #(
    parameter int WIDTH  = 8,
    parameter int ADDR_W = 4,
    parameter logic [ADDR_W-1:0] DIR_ADDR = 4'hA
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic                          bus_wr,
    input  logic [WIDTH-1:0]              bus_wdata,
    output logic [WIDTH-1:0]              bus_rdata,
    input  logic [WIDTH-1:0]              pwm_chan_en,
    input  logic                          pwm_shut_en,
    input  logic [pdo_pkg::TIM_BITS-1:0]  tim_oc_en,
    input  logic [1:0]                    ser_en,
    input  logic [1:0]                    ser_out,
    output logic [WIDTH-1:0]              pin_oe
);
    import pdo_pkg::*;

    logic [WIDTH-1:0] dir_q;
    logic [WIDTH-1:0] tim_vec;
    logic [WIDTH-1:0] ser_en_vec;
    logic [WIDTH-1:0] ser_out_vec;

    pdo_dir_reg #(
        .WIDTH (WIDTH),
        .ADDR_W(ADDR_W),
        .ADDR  (DIR_ADDR)
    ) u_reg (
        .clk  (clk),
        .rst_n(rst_n),
        .addr (bus_addr),
        .wr   (bus_wr),
        .wdata(bus_wdata),
        .dir_q(dir_q),
        .rdata(bus_rdata)
    );

    always_comb begin
        tim_vec                  = '0;
        tim_vec[TIM_BITS-1:0]    = tim_oc_en;
        ser_en_vec               = '0;
        ser_en_vec[SER_BIT_LO]   = ser_en[0];
        ser_en_vec[SER_BIT_HI]   = ser_en[1];
        ser_out_vec              = '0;
        ser_out_vec[SER_BIT_LO]  = ser_out[0];
        ser_out_vec[SER_BIT_HI]  = ser_out[1];
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        pdo_bit_arb #(
            .HAS_SHUT(i == WIDTH - 1),
            .HAS_TIM (i < TIM_BITS),
            .HAS_SER ((i == SER_BIT_LO) || (i == SER_BIT_HI))
        ) u_arb (
            .soft_dir(dir_q[i]),
            .pwm_en  (pwm_chan_en[i]),
            .shut_en (pwm_shut_en),
            .tim_en  (tim_vec[i]),
            .ser_en  (ser_en_vec[i]),
            .ser_out (ser_out_vec[i]),
            .oe      (pin_oe[i])
        );
    end
endmodule

// File: rtl/pdo_arbiter_chk.sv
module pdo_arbiter_chk #(
    parameter int WIDTH  = 8,
    parameter int ADDR_W = 4,
    parameter logic [ADDR_W-1:0] DIR_ADDR = 4'hA
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [ADDR_W-1:0]             bus_addr,
    input logic                          bus_wr,
    input logic [WIDTH-1:0]              bus_wdata,
    input logic [WIDTH-1:0]              bus_rdata,
    input logic [WIDTH-1:0]              pwm_chan_en,
    input logic                          pwm_shut_en,
    input logic [pdo_pkg::TIM_BITS-1:0]  tim_oc_en,
    input logic [1:0]                    ser_en,
    input logic [1:0]                    ser_out,
    input logic [WIDTH-1:0]              pin_oe
);
    import pdo_pkg::*;

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == DIR_ADDR) |=>
        (bus_addr != DIR_ADDR || bus_rdata == $past(bus_wdata))); // R2

    AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == DIR_ADDR && $past(bus_addr) == DIR_ADDR && !$past(bus_wr))
        |-> $stable(bus_rdata)); // R10

    AST_PLAIN_FOLLOWS_REG: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_chan_en == '0 && !pwm_shut_en && tim_oc_en == '0 && ser_en == '0
         && bus_addr == DIR_ADDR) |-> (pin_oe == bus_rdata)); // R4

    AST_PWM_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        ((pwm_chan_en[WIDTH-2:0] & ~pin_oe[WIDTH-2:0]) == '0)); // R5

    AST_SHUT_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        pwm_shut_en |-> !pin_oe[WIDTH-1]); // R6

    AST_TIM_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        ((tim_oc_en & ~pin_oe[TIM_BITS-1:0]) == '0)); // R7

    AST_OTHER_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr != DIR_ADDR) |-> (bus_rdata == '0)); // R3
endmodule

bind pdo_arbiter pdo_arbiter_chk #(
    .WIDTH   (WIDTH),
    .ADDR_W  (ADDR_W),
    .DIR_ADDR(DIR_ADDR)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .pwm_chan_en(pwm_chan_en),
    .pwm_shut_en(pwm_shut_en),
    .tim_oc_en  (tim_oc_en),
    .ser_en     (ser_en),
    .ser_out    (ser_out),
    .pin_oe     (pin_oe)
);

// File: tb/tb_pdo_arbiter.sv
`timescale 1ns/1ps
module tb_pdo_arbiter;
    localparam logic [3:0] A_DIR = 4'hA;
    localparam int NVEC = 12;
    // fields: reg(8) pwm(8) shut(1) tim(3) ser_en(2) ser_out(2) expected oe(8)
    localparam logic [31:0] VEC [0:NVEC-1] = '{
        {8'hA5, 8'h00, 1'b0, 3'b000, 2'b00, 2'b00, 8'hA5}, // R4
        {8'h00, 8'hFF, 1'b0, 3'b000, 2'b00, 2'b00, 8'hFF}, // R5
        {8'h00, 8'hFF, 1'b1, 3'b000, 2'b00, 2'b00, 8'h7F}, // R6
        {8'h80, 8'h00, 1'b1, 3'b000, 2'b00, 2'b00, 8'h00}, // R6
        {8'h00, 8'h00, 1'b0, 3'b111, 2'b00, 2'b00, 8'h07}, // R7
        {8'h00, 8'h00, 1'b0, 3'b000, 2'b11, 2'b11, 8'h05}, // R8
        {8'hFF, 8'h00, 1'b0, 3'b000, 2'b11, 2'b00, 8'hFA}, // R8
        {8'hFF, 8'h00, 1'b0, 3'b101, 2'b11, 2'b00, 8'hFF}, // R7
        {8'h00, 8'h04, 1'b0, 3'b000, 2'b10, 2'b00, 8'h04}, // R5
        {8'h7F, 8'h00, 1'b1, 3'b000, 2'b00, 2'b00, 8'h7F}, // R9
        {8'h3C, 8'h00, 1'b0, 3'b000, 2'b01, 2'b01, 8'h3D}, // R8
        {8'h38, 8'h00, 1'b0, 3'b000, 2'b10, 2'b10, 8'h3C}  // R8
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] bus_addr = A_DIR;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] pwm_chan_en = '0;
    logic       pwm_shut_en = 1'b0;
    logic [2:0] tim_oc_en = '0;
    logic [1:0] ser_en = '0;
    logic [1:0] ser_out = '0;
    logic [7:0] pin_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    pdo_arbiter dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_chan_en(pwm_chan_en),
        .pwm_shut_en(pwm_shut_en), .tim_oc_en(tim_oc_en), .ser_en(ser_en),
        .ser_out(ser_out), .pin_oe(pin_oe)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic clear_ovr();
        pwm_chan_en = '0; pwm_shut_en = 1'b0; tim_oc_en = '0; ser_en = '0; ser_out = '0;
    endtask

    task automatic write_reg(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = A_DIR;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1 during and after reset
        repeat (3) @(negedge clk);
        #0.5;
        check("R1 rdata in reset", bus_rdata, 8'h00);
        check("R1 oe in reset", pin_oe, 8'h00);
        rst_n = 1'b1;
        @(negedge clk); #0.5;
        check("R1 rdata after reset", bus_rdata, 8'h00);
        check("R1 oe after reset", pin_oe, 8'h00);

        // Vector table
        for (int k = 0; k < NVEC; k++) begin
            clear_ovr();
            write_reg(A_DIR, VEC[k][31:24]);
            pwm_chan_en = VEC[k][23:16];
            pwm_shut_en = VEC[k][15];
            tim_oc_en   = VEC[k][14:12];
            ser_en      = VEC[k][11:10];
            ser_out     = VEC[k][9:8];
            #0.5;
            check($sformatf("vector %0d oe (R4-table)", k), pin_oe, VEC[k][7:0]);
            check($sformatf("R10 vector %0d readback", k), bus_rdata, VEC[k][31:24]);
        end
        clear_ovr();

        // R2 write not visible before the edge, visible after
        write_reg(A_DIR, 8'h11);
        @(negedge clk);
        bus_wr = 1'b1; bus_wdata = 8'h6C;
        #1.5;
        check("R2 before edge", bus_rdata, 8'h11);
        @(negedge clk);
        bus_wr = 1'b0;
        #0.5;
        check("R2 after edge", bus_rdata, 8'h6C);
        check("R2 oe follows", pin_oe, 8'h6C);

        // R3 other address ignored and reads zero
        write_reg(4'h3, 8'hFF);
        #0.5;
        check("R3 write elsewhere ignored", bus_rdata, 8'h6C);
        check("R3 oe unchanged", pin_oe, 8'h6C);
        bus_addr = 4'h3;
        #0.5;
        check("R3 other address reads zero", bus_rdata, 8'h00);
        bus_addr = A_DIR;

        // R11 same-cycle response
        @(negedge clk);
        pwm_chan_en = 8'h01;
        #0.5;
        check("R11 same cycle assert", pin_oe, 8'h6D);
        pwm_chan_en = 8'h00;
        #0.5;
        check("R11 same cycle release", pin_oe, 8'h6C);

        // R9 shutdown leaves lower bits alone with PWM on them
        pwm_chan_en = 8'hFF; pwm_shut_en = 1'b1;
        #0.5;
        check("R9 lower bits keep PWM", pin_oe, 8'h7F);
        clear_ovr();

        // R10 readback after heavy overrides
        pwm_chan_en = 8'hFF; tim_oc_en = 3'b111; ser_en = 2'b11;
        @(negedge clk); @(negedge clk);
        check("R10 register untouched", bus_rdata, 8'h6C);
        clear_ovr();
        #0.5;
        check("R10 oe restored", pin_oe, 8'h6C);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule